// File: doc/BRIEF.md
# Receive Frame Packer with Word Readout

This block takes the bytes of incoming Ethernet frames and files each accepted frame into a shared word-wide receive store. Each frame is wrapped as follows: a fixed marker word, a descriptor word with the stored length and a good-status flag, the frame bytes zero-padded to the 60-byte minimum, the Ethernet CRC-32 over those bytes, and zero fill up to a 4-byte boundary. Bytes are packed little-endian into 32-bit words, with the earliest byte in bits 7:0.

The host drains the store one word per read strobe. A tracker on the read side treats the first word of a frame as the marker and the second as the descriptor. From the descriptor it learns how many data words follow. When the last data word of the frame has been read, the pending-frame count drops by one. A frame is admitted only when reception is enabled and the store still has room for the largest possible wrapped frame. Writing zero to the count register empties the whole store.

Top module: `rxp_frame_packer`

## Requirements
- R1: Admission is decided on the start byte of a frame. The frame is stored only if `rx_en` is high and at least 384 words are free, which is the wrapped size of a 1522-byte frame. Otherwise every byte of that frame is dropped. The store never holds more than DEPTH words.
- R2: A stored frame reads back as follows: the MAGIC word, then the descriptor, then the frame bytes packed little-endian (first byte in bits 7:0), then the padding, then the CRC, then the fill.
- R3: A frame shorter than 60 bytes is extended with zero bytes to exactly 60 bytes.
- R4: The descriptor holds the padded length plus 4 in bits 15:0. Bit 16 is 1, marking good status, and bits 31:17 are 0.
- R5: The CRC is the Ethernet CRC-32 over the frame bytes and the padding: reflected polynomial 0xEDB88320, initial value all ones, result inverted. It is stored least significant byte first and followed by zero bytes up to a word boundary.
- R6: `frame_count` rises by one for each frame that is completely stored.
- R7: `rx_irq` is set when a frame is stored and stays set until `irq_clr` is pulsed. If both happen in the same cycle, the set wins.
- R8: The read tracker uses the descriptor to work out ceil(length/4) data words. `frame_count` drops by one on the read of the last of those words and not earlier.
- R9: A read strobe while `frame_count` is zero returns zero and consumes nothing from the store.
- R10: Writing zero to the count register empties the store, clears the count, resets read tracking and drops any frame still being stored. Writing any nonzero value has no effect.
- R11: Bytes beyond the 1522nd byte of a frame are discarded, so the largest descriptor length is 1526.
- R12: A start byte that arrives while the previous frame is still being wrapped (padded, stamped and sealed) is refused, and that whole frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable, sampled at the start byte |
| in_valid | input | 1 | Byte strobe for `in_data` |
| in_sop | input | 1 | Marks the first byte of a frame |
| in_eop | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Frame byte |
| rd_req | input | 1 | Read strobe for the data register |
| rd_data | output | 32 | Word returned, valid the cycle after `rd_req` |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 32 | Count register write value; zero flushes |
| irq_clr | input | 1 | Clears the receive interrupt status |
| frame_count | output | AW+1 (10) | Number of complete frames waiting |
| rx_irq | output | 1 | Receive interrupt status |

## Verification
The main function is exercised with frame lengths of 20, 60, 61, 63, 100 and 1530 bytes:
- The 20-byte frame shows that padding is applied.
- The 60-byte frame shows that no padding is added at the boundary.
- The 61-byte and 63-byte frames move the CRC into different byte lanes, which exercises fill of three and one bytes.
- The 1530-byte frame exposes the length cap.

A run of eight minimum-size frames followed by a ninth separates correct space admission from overflow. A frame with reception disabled and a frame started right after another one each show refusal of a whole frame. Reads at an empty count and in the middle of a frame show that the count falls only at a frame's last data word.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [2:0] {
        W_IDLE, W_DATA, W_PAD, W_CRC, W_FILL, W_HDR, W_MAGIC
    } wr_state_e;

    typedef enum logic [1:0] {
        P_MAGIC, P_HDR, P_DATA
    } rd_pos_e;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    // One byte of reflected CRC-32, LSB first
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] x;
        x = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            x = x[0] ? ((x >> 1) ^ CRC_POLY) : (x >> 1);
        end
        return x;
    endfunction

endpackage

// File: rtl/rxp_store.sv
module rxp_store #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxp_writer.sv
module rxp_writer
    import rxp_pkg::*;
#(
    parameter int          AW      = 9,
    parameter logic [31:0] MAGIC   = 32'h5A17_C3E9,
    parameter int          MIN_LEN = 60,
    parameter int          MAX_LEN = 1522
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          rx_en,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [7:0]    in_data,
    input  logic          space_ok,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [31:0]   mem_wdata,
    output logic [AW:0]   wp,
    output logic          commit
);
    localparam logic [15:0] MIN_L = 16'(MIN_LEN);
    localparam logic [15:0] MAX_L = 16'(MAX_LEN);

    typedef struct packed {
        wr_state_e   st;
        logic [AW:0] wp;
        logic [AW-1:0] base;
        logic [31:0] acc;
        logic [1:0]  lane;
        logic [1:0]  k;
        logic [15:0] len;
        logic [31:0] crc;
    } wr_t;

    localparam wr_t WR_RST = '{st: W_IDLE, wp: '0, base: '0, acc: '0,
                               lane: '0, k: '0, len: '0, crc: '1};

    wr_t r_q, r_d;
    logic       push, upd;
    logic [7:0] pb;
    logic [31:0] crc_inv;

    always_comb begin
        r_d       = r_q;
        mem_we    = 1'b0;
        mem_waddr = r_q.wp[AW-1:0];
        mem_wdata = '0;
        commit    = 1'b0;
        push      = 1'b0;
        upd       = 1'b0;
        pb        = 8'h00;
        crc_inv   = ~r_q.crc;

        case (r_q.st)
            W_IDLE: begin
                if (in_valid && in_sop && rx_en && space_ok) begin
                    r_d.base = r_q.wp[AW-1:0];
                    r_d.wp   = r_q.wp + (AW+1)'(2);
                    r_d.lane = '0;
                    r_d.len  = '0;
                    r_d.crc  = '1;
                    push     = 1'b1;
                    upd      = 1'b1;
                    pb       = in_data;
                    r_d.st   = in_eop ? W_PAD : W_DATA;
                end
            end
            W_DATA: begin
                if (in_valid && r_q.len < MAX_L) begin
                    push = 1'b1;
                    upd  = 1'b1;
                    pb   = in_data;
                end
                if (in_valid && in_eop) r_d.st = W_PAD;
            end
            W_PAD: begin
                if (r_q.len < MIN_L) begin
                    push = 1'b1;
                    upd  = 1'b1;
                end else begin
                    r_d.st = W_CRC;
                    r_d.k  = '0;
                end
            end
            W_CRC: begin
                push  = 1'b1;
                pb    = crc_inv[{r_q.k, 3'b000} +: 8];
                r_d.k = r_q.k + 2'd1;
                if (r_q.k == 2'd3) r_d.st = W_FILL;
            end
            W_FILL: begin
                if (r_q.lane != 2'd0) push = 1'b1;
                else                  r_d.st = W_HDR;
            end
            W_HDR: begin
                mem_we    = 1'b1;
                mem_waddr = r_q.base + AW'(1);
                mem_wdata = {15'h0, 1'b1, 16'(r_q.len + 16'd4)};
                r_d.st    = W_MAGIC;
            end
            W_MAGIC: begin
                mem_we    = 1'b1;
                mem_waddr = r_q.base;
                mem_wdata = MAGIC;
                commit    = 1'b1;
                r_d.st    = W_IDLE;
            end
            default: r_d.st = W_IDLE;
        endcase

        if (push) begin
            r_d.acc[{r_d.lane, 3'b000} +: 8] = pb;
            if (r_d.lane == 2'd3) begin
                mem_we    = 1'b1;
                mem_waddr = r_d.wp[AW-1:0];
                mem_wdata = r_d.acc;
                r_d.wp    = r_d.wp + (AW+1)'(1);
            end
            r_d.lane = r_d.lane + 2'd1;
        end
        if (upd) begin
            r_d.crc = crc32_step(r_d.crc, pb);
            r_d.len = r_d.len + 16'd1;
        end

        if (flush) begin
            r_d    = WR_RST;
            mem_we = 1'b0;
            commit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= WR_RST;
        else        r_q <= r_d;
    end

    assign wp = r_q.wp;
endmodule

// File: rtl/rxp_reader.sv
module rxp_reader
    import rxp_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          rd_req,
    input  logic          have_frame,
    output logic [AW-1:0] mem_raddr,
    input  logic [31:0]   mem_rdata,
    output logic [31:0]   rd_data,
    output logic [AW:0]   rp,
    output logic          done
);
    typedef struct packed {
        rd_pos_e     pos;
        logic [AW:0] rp;
        logic [14:0] remain;
        logic [31:0] data;
    } rd_t;

    rd_t r_q, r_d;
    logic [16:0] up;

    always_comb begin
        r_d  = r_q;
        done = 1'b0;
        up   = {1'b0, mem_rdata[15:0]} + 17'd3;
        if (flush) begin
            r_d.pos    = P_MAGIC;
            r_d.rp     = '0;
            r_d.remain = '0;
        end else if (rd_req) begin
            if (!have_frame) begin
                r_d.data = '0;
            end else begin
                r_d.data = mem_rdata;
                r_d.rp   = r_q.rp + (AW+1)'(1);
                case (r_q.pos)
                    P_MAGIC: r_d.pos = P_HDR;
                    P_HDR: begin
                        r_d.remain = up[16:2];
                        r_d.pos    = P_DATA;
                    end
                    default: begin
                        r_d.remain = r_q.remain - 15'd1;
                        if (r_q.remain == 15'd1) begin
                            r_d.pos = P_MAGIC;
                            done    = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{pos: P_MAGIC, rp: '0, remain: '0, data: '0};
        else        r_q <= r_d;
    end

    assign mem_raddr = r_q.rp[AW-1:0];
    assign rd_data   = r_q.data;
    assign rp        = r_q.rp;
endmodule

// File: rtl/rxp_frame_packer.sv
module rxp_frame_packer #(
    parameter int          DEPTH   = 512,
    parameter logic [31:0] MAGIC   = 32'h5A17_C3E9,
    parameter int          MIN_LEN = 60,
    parameter int          MAX_LEN = 1522,
    localparam int         AW      = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [7:0]  in_data,
    input  logic        rd_req,
    output logic [31:0] rd_data,
    input  logic        cnt_wr,
    input  logic [31:0] cnt_wdata,
    input  logic        irq_clr,
    output logic [AW:0] frame_count,
    output logic        rx_irq
);
    localparam int WORST_WORDS = 2 + (MAX_LEN + 4 + 3) / 4;
    localparam logic [AW:0] WORST_V = (AW+1)'(WORST_WORDS);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW:0] cnt;
        logic        irq;
    } top_t;

    top_t r_q, r_d;

    logic          flush, commit, done, space_ok, mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [AW:0]   wp, rp, used, free_w;

    assign flush = cnt_wr && (cnt_wdata == 32'h0);

    rxp_writer #(.AW(AW), .MAGIC(MAGIC), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_wr (
        .clk(clk), .rst_n(rst_n), .flush(flush), .rx_en(rx_en),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .space_ok(space_ok), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .wp(wp), .commit(commit)
    );

    rxp_store #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    rxp_reader #(.AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .flush(flush), .rd_req(rd_req),
        .have_frame(r_q.cnt != '0), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .rd_data(rd_data), .rp(rp), .done(done)
    );

    always_comb begin
        used     = wp - rp;
        free_w   = DEPTH_V - used;
        space_ok = free_w >= WORST_V;
        r_d      = r_q;
        if (flush) begin
            r_d.cnt = '0;
        end else begin
            case ({commit, done})
                2'b10:   r_d.cnt = r_q.cnt + (AW+1)'(1);
                2'b01:   r_d.cnt = r_q.cnt - (AW+1)'(1);
                default: r_d.cnt = r_q.cnt;
            endcase
        end
        if (commit)       r_d.irq = 1'b1;
        else if (irq_clr) r_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: '0, irq: 1'b0};
        else        r_q <= r_d;
    end

    assign frame_count = r_q.cnt;
    assign rx_irq      = r_q.irq;
endmodule

// File: rtl/rxp_checks.sv
module rxp_checks #(
    parameter int AW    = 9,
    parameter int DEPTH = 512
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        commit,
    input logic        done,
    input logic [AW:0] frame_count,
    input logic        rd_req,
    input logic [31:0] rd_data,
    input logic        rx_irq,
    input logic [AW:0] used
);
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        used <= (AW+1)'(DEPTH));

    assert_count_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && commit && !done) |=> frame_count == $past(frame_count) + (AW+1)'(1));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !commit && !done) |=> $stable(frame_count));

    assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rx_irq);

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !flush && frame_count == '0) |=> rd_data == 32'h0);

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> frame_count == '0);
endmodule

bind rxp_frame_packer rxp_checks #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .commit(commit), .done(done),
    .frame_count(frame_count), .rd_req(rd_req), .rd_data(rd_data),
    .rx_irq(rx_irq), .used(used)
);

// File: tb/sim_rxp_frame_packer.sv
module sim_rxp_frame_packer;
    localparam int          DEPTH = 512;
    localparam logic [31:0] MAGIC = 32'h5A17_C3E9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        rd_req = 1'b0, cnt_wr = 1'b0, irq_clr = 1'b0;
    logic [31:0] cnt_wdata = 32'h0;
    logic [31:0] rd_data;
    logic [9:0]  frame_count;
    logic        rx_irq;

    rxp_frame_packer #(.DEPTH(DEPTH), .MAGIC(MAGIC)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
        .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data), .rd_req(rd_req),
        .rd_data(rd_data), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .irq_clr(irq_clr), .frame_count(frame_count), .rx_irq(rx_irq)
    );

    always #10 clk = ~clk;

    int n_checks = 0, n_fail = 0, model_used = 0, exp_cnt = 0, cyc = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(logic [7:0] d[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (d[i]) begin
            c ^= {24'h0, d[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Driver: pushes the expected word image of an admitted frame into exp_q
    task automatic send_frame(int len, int seed, int gap, bit busy);
        logic [7:0] fb[$];
        logic [7:0] st[$];
        logic [31:0] crc;
        int eff, pl;
        bit accept;
        for (int i = 0; i < len; i++) fb.push_back(8'(seed + i * 7 + 1));
        accept = rx_en && !busy && (DEPTH - model_used) >= 384;
        if (accept) begin
            eff = (len > 1522) ? 1522 : len;
            pl  = (eff < 60) ? 60 : eff;
            for (int i = 0; i < pl; i++) st.push_back(i < eff ? fb[i] : 8'h00);
            crc = ref_crc(st);
            for (int i = 0; i < 4; i++) st.push_back(crc[8*i +: 8]);
            while (st.size() % 4 != 0) st.push_back(8'h00);
            exp_q.push_back(MAGIC);
            exp_q.push_back({15'h0, 1'b1, 16'(pl + 4)});
            for (int w = 0; w < st.size() / 4; w++)
                exp_q.push_back({st[4*w+3], st[4*w+2], st[4*w+1], st[4*w]});
            model_used += 2 + st.size() / 4;
            exp_cnt++;
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1); in_data = fb[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic rd_word(output logic [31:0] w);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        w = rd_data;
    endtask

    // Monitor: pops expected words and compares them as frames are drained
    task automatic read_frame();
        logic [31:0] w, e, h;
        int n;
        if (exp_q.size() < 2) begin
            chk("R8 queue", 32'(exp_q.size()), 32'd2);
            return;
        end
        rd_word(w); e = exp_q.pop_front(); chk("R2 marker", w, e);
        rd_word(w); h = exp_q.pop_front(); chk("R4 descriptor", w, h);
        chk("R8 count mid-frame", 32'(frame_count), 32'(exp_cnt));
        n = (int'(h[15:0]) + 3) / 4;
        for (int i = 0; i < n; i++) begin
            rd_word(w); e = exp_q.pop_front();
            chk("R2/R3/R5 data word", w, e);
            if (i < n - 1 && i == 0) chk("R8 count before last", 32'(frame_count), 32'(exp_cnt));
        end
        exp_cnt--;
        model_used -= 2 + n;
        chk("R8 count after last", 32'(frame_count), 32'(exp_cnt));
    endtask

    task automatic write_cnt(logic [31:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset count", 32'(frame_count), 32'd0);
        chk("R7 reset irq", 32'(rx_irq), 32'd0);
        rd_word(w);
        chk("R9 empty read", w, 32'h0);
        chk("R9 count stays", 32'(frame_count), 32'd0);

        rx_en = 1'b1;
        send_frame(20, 1, 100, 0);
        chk("R6 count 1", 32'(frame_count), 32'(exp_cnt));
        chk("R7 irq set", 32'(rx_irq), 32'd1);
        @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk("R7 irq cleared", 32'(rx_irq), 32'd0);
        send_frame(60, 2, 100, 0);
        send_frame(61, 3, 100, 0);
        send_frame(63, 4, 100, 0);
        send_frame(100, 5, 100, 0);
        chk("R6 count 5", 32'(frame_count), 32'(exp_cnt));
        chk("R7 irq again", 32'(rx_irq), 32'd1);
        for (int f = 0; f < 5; f++) read_frame();

        rx_en = 1'b0;
        send_frame(70, 6, 100, 0);
        chk("R1 disabled refused", 32'(frame_count), 32'd0);
        rd_word(w);
        chk("R1 nothing stored", w, 32'h0);
        rx_en = 1'b1;

        for (int f = 0; f < 9; f++) send_frame(60, 10 + f, 90, 0);
        chk("R1 space limit count", 32'(frame_count), 32'd8);
        for (int f = 0; f < 8; f++) read_frame();

        send_frame(40, 30, 0, 0);
        send_frame(40, 31, 100, 1);
        chk("R12 busy refused", 32'(frame_count), 32'd1);
        read_frame();
        rd_word(w);
        chk("R12 no second frame", w, 32'h0);

        send_frame(64, 40, 100, 0);
        send_frame(64, 41, 100, 0);
        write_cnt(32'd5);
        chk("R10 nonzero write ignored", 32'(frame_count), 32'd2);
        write_cnt(32'd0);
        chk("R10 flush count", 32'(frame_count), 32'd0);
        exp_q.delete(); exp_cnt = 0; model_used = 0;
        rd_word(w);
        chk("R10 flushed read", w, 32'h0);
        send_frame(30, 42, 100, 0);
        read_frame();

        send_frame(1530, 50, 100, 0);
        chk("R11 long frame stored", 32'(frame_count), 32'd1);
        read_frame();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule